// File: doc/BRIEF.md
# LCD Column Scan and Drive-Level Encoder

This block feeds the column side of a passive matrix panel with 240 columns and 160 lines. On every falling edge of an external shift clock it reads one full 240-bit line out of display memory through a simple line-read port. It holds that line and turns each pixel into a 2-bit drive-level code. The code depends on the pixel bit and on the frame alternation signal. An active-low display-off input forces every column to the ground level.

An internal line counter sets which memory line is read. A frame-start pulse that is high at the shift-clock falling edge restarts the scan at line 0. Otherwise the counter steps on and wraps after the last line.

The shift clock, frame-start, alternation and display-off inputs are asynchronous to the system clock. Each one passes through two synchronizing flops before use. The memory read is combinational: the block presents a line address, and the data returned for that address is captured in the falling-edge cycle.

Top module: `lcd_col_scan`

## Requirements
- R1: After reset the held line is all zeros and the line counter is 0. While reset is applied, every column code is 2'b00. The first shift-clock falling edge after reset without frame-start latches memory line 0.
- R2: With display enabled and alternation low, a held pixel of 0 gives code 2'b01 and a held pixel of 1 gives code 2'b00.
- R3: With display enabled and alternation high, a held pixel of 0 gives code 2'b10 and a held pixel of 1 gives code 2'b11.
- R4: While the display-off input is low, every column code is 2'b00, whatever the held data and the alternation signal.
- R5: Each shift-clock falling edge latches all 240 bits of the memory line at the presented address. Column c, whose code sits at level_o[2c+1:2c], takes bit c of the memory data.
- R6: A falling edge without frame-start latches the line at the counter and advances the counter by one, wrapping from 159 to 0.
- R7: A falling edge with frame-start high latches line 0 and sets the counter to 1. The presented address is 0 whenever the synchronized frame-start is high.
- R8: A rising edge of the shift clock neither latches a line nor changes the counter.
- R9: A shift-clock fall is acted on at the third system-clock rising edge after it. Changes on alternation and display-off reach the outputs after the second system-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_clk_i | input | 1 | Line shift clock, asynchronous |
| frame_start_i | input | 1 | Frame-start pulse, asynchronous |
| alt_i | input | 1 | Frame alternation (drive polarity), asynchronous |
| disp_on_ni | input | 1 | Display-off when low, asynchronous |
| mem_rd_addr_o | output | 8 | Line address to display memory |
| mem_rd_data_i | input | 240 | Line data returned for mem_rd_addr_o |
| level_o | output | 480 | Per-column drive-level codes, 2 bits per column |

## Verification
A shift-clock fall takes effect after three system-clock rising edges: two synchronizer stages and the latch edge. Alternation and display-off changes take effect after two. The bench drives every input on a falling system-clock edge. It holds each shift-clock phase for four cycles and samples only on a falling edge after that, so every result has settled when it is read.

The vector table mixes frame-start, alternation and display-off settings, and each entry names the memory line that must be held afterwards. Directed runs then cover the reset state, a rising shift-clock edge, and a full 160-line scan through the wrap.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    LVL_GND   = 2'b00,
    LVL_LOW   = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_TOP   = 2'b11
  } drv_lvl_e;

  // pixel x alternation table
  function automatic drv_lvl_e encode_px(input logic px, input logic alt);
    unique case ({alt, px})
      2'b00:   return LVL_LOW;
      2'b01:   return LVL_GND;
      2'b10:   return LVL_HIGH;
      default: return LVL_TOP;
    endcase
  endfunction

endpackage

// File: rtl/lcd_in_sync.sv
module lcd_in_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lcd_line_scan.sv
module lcd_line_scan #(
  parameter int NUM_COLS  = 240,
  parameter int NUM_LINES = 160,
  parameter int AW        = $clog2(NUM_LINES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_s_i,
  input  logic                fs_s_i,
  input  logic [NUM_COLS-1:0] mem_rd_data_i,
  output logic [AW-1:0]       mem_rd_addr_o,
  output logic [NUM_COLS-1:0] line_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_LINES - 1);

  logic                shift_prev_q;
  logic                fall;
  logic [AW-1:0]       cnt_q, cnt_d;
  logic [NUM_COLS-1:0] line_q;

  assign fall = shift_prev_q & ~shift_s_i;
  assign mem_rd_addr_o = fs_s_i ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (fall) begin
      if (fs_s_i)             cnt_d = AW'(1);
      else if (cnt_q == LAST) cnt_d = '0;
      else                    cnt_d = cnt_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_prev_q <= 1'b0;
      cnt_q        <= '0;
      line_q       <= '0;
    end else begin
      shift_prev_q <= shift_s_i;
      cnt_q        <= cnt_d;
      if (fall) line_q <= mem_rd_data_i;
    end
  end

  assign line_o = line_q;

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !fs_s_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + AW'(1));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !fs_s_i && cnt_q == LAST) |=> cnt_q == '0);
  assert_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && fs_s_i) |=> (cnt_q == AW'(1)) && (line_q == $past(mem_rd_data_i)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(cnt_q) && $stable(line_q));
  assert_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall);
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 240
) (
  input  logic [NUM_COLS-1:0]   line_i,
  input  logic                  alt_i,
  input  logic                  disp_en_i,
  output logic [2*NUM_COLS-1:0] level_o
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    drv_lvl_e lvl;
    assign lvl = disp_en_i ? encode_px(line_i[c], alt_i) : LVL_GND;
    assign level_o[2*c +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_col_scan.sv
module lcd_col_scan #(
  parameter int NUM_COLS  = 240,
  parameter int NUM_LINES = 160,
  parameter int AW        = $clog2(NUM_LINES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_clk_i,
  input  logic                  frame_start_i,
  input  logic                  alt_i,
  input  logic                  disp_on_ni,
  output logic [AW-1:0]         mem_rd_addr_o,
  input  logic [NUM_COLS-1:0]   mem_rd_data_i,
  output logic [2*NUM_COLS-1:0] level_o
);
  logic shift_s, fs_s, alt_s, don_s;
  logic [NUM_COLS-1:0] line;

  // reset value 0 on display-on keeps outputs at ground until synced
  lcd_in_sync #(.W(4), .RST_VAL(4'b0000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({shift_clk_i, frame_start_i, alt_i, disp_on_ni}),
    .q_o    ({shift_s, fs_s, alt_s, don_s})
  );

  lcd_line_scan #(.NUM_COLS(NUM_COLS), .NUM_LINES(NUM_LINES), .AW(AW)) u_scan (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .shift_s_i     (shift_s),
    .fs_s_i        (fs_s),
    .mem_rd_data_i (mem_rd_data_i),
    .mem_rd_addr_o (mem_rd_addr_o),
    .line_o        (line)
  );

  lcd_level_enc #(.NUM_COLS(NUM_COLS)) u_enc (
    .line_i    (line),
    .alt_i     (alt_s),
    .disp_en_i (don_s),
    .level_o   (level_o)
  );

  assert_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !don_s |-> level_o == '0);
  assert_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_s |-> mem_rd_addr_o == '0);
  assert_col0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (don_s && alt_s) |-> level_o[1]);
endmodule

// File: tb/lcd_col_scan_tb_top.sv
`timescale 1ns/1ps
module lcd_col_scan_tb_top;
  localparam int NC = 240;
  localparam int NL = 160;
  localparam int AW = 8;
  localparam int BW = 2 * NC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shift_clk = 1'b1;
  logic          fstart = 1'b0;
  logic          alt = 1'b0;
  logic          don_n = 1'b1;
  logic [AW-1:0] addr;
  logic [NC-1:0] mdata;
  logic [BW-1:0] level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_col_scan dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .shift_clk_i   (shift_clk),
    .frame_start_i (fstart),
    .alt_i         (alt),
    .disp_on_ni    (don_n),
    .mem_rd_addr_o (addr),
    .mem_rd_data_i (mdata),
    .level_o       (level)
  );

  function automatic logic pix(input int ln, input int col);
    return ((col * 5 + ln * 11) % 3) == 0;
  endfunction

  always_comb
    for (int c = 0; c < NC; c++) mdata[c] = pix(int'(addr), c);

  // expected bus from requirements R2, R3, R4 (ln < 0: all-zero line)
  function automatic logic [BW-1:0] exp_bus(input int ln, input logic a, input logic dn);
    logic [BW-1:0] r;
    for (int c = 0; c < NC; c++) begin
      logic p;
      p = (ln < 0) ? 1'b0 : pix(ln, c);
      if (!dn)    r[2*c +: 2] = 2'b00;
      else if (a) r[2*c +: 2] = p ? 2'b11 : 2'b10;
      else        r[2*c +: 2] = p ? 2'b00 : 2'b01;
    end
    return r;
  endfunction

  task automatic check_bus(input string tag, input logic [BW-1:0] exp);
    n_chk++;
    if (level !== exp) begin
      int col;
      col = 0;
      for (int c = NC - 1; c >= 0; c--)
        if (level[2*c +: 2] !== exp[2*c +: 2]) col = c;
      n_fail++;
      $display("FAIL %s col %0d: actual %b expected %b", tag, col,
               level[2*col +: 2], exp[2*col +: 2]);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_fall(input logic fs);
    @(negedge clk);
    fstart = fs;
    shift_clk = 1'b0;
    settle();
  endtask

  task automatic shift_rise();
    @(negedge clk);
    shift_clk = 1'b1;
    settle();
    fstart = 1'b0;
  endtask

  // {frame_start, alt, display_on_n, expected line}
  localparam int NV = 10;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'd0},
    {1'b0, 1'b0, 1'b1, 8'd1},
    {1'b0, 1'b1, 1'b1, 8'd2},
    {1'b1, 1'b0, 1'b1, 8'd0},
    {1'b0, 1'b1, 1'b1, 8'd1},
    {1'b0, 1'b1, 1'b0, 8'd2},
    {1'b0, 1'b0, 1'b0, 8'd3},
    {1'b0, 1'b1, 1'b1, 8'd4},
    {1'b1, 1'b1, 1'b1, 8'd0},
    {1'b0, 1'b0, 1'b1, 8'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    check_bus("R1 reset", '0);
    rst_n = 1'b1;
    settle();
    check_bus("R1 zero line", exp_bus(-1, 1'b0, 1'b1));

    for (int i = 0; i < NV; i++) begin
      logic fs, a, dn;
      int ln;
      string tag;
      {fs, a, dn} = VEC[i][10:8];
      ln = int'(VEC[i][7:0]);
      @(negedge clk);
      alt = a;
      don_n = dn;
      shift_fall(fs);
      if (!dn)     tag = "R4";
      else if (fs) tag = "R7";
      else if (a)  tag = "R3";
      else         tag = "R2";
      check_bus($sformatf("%s/R5 vec %0d", tag, i), exp_bus(ln, a, dn));
      shift_rise();
    end

    // R8: rising edge leaves the held line (counter now 2)
    alt = 1'b0;
    don_n = 1'b1;
    shift_fall(1'b0);
    check_bus("R5 line 2", exp_bus(2, 1'b0, 1'b1));
    shift_rise();
    check_bus("R8 rise ignored", exp_bus(2, 1'b0, 1'b1));

    // R9: alternation reaches outputs two edges later
    @(negedge clk);
    alt = 1'b1;
    repeat (2) @(negedge clk);
    check_bus("R9 alt latency", exp_bus(2, 1'b1, 1'b1));
    alt = 1'b0;

    // R6: full scan and wrap
    shift_fall(1'b1);
    shift_rise();
    for (int k = 1; k < NL; k++) begin
      shift_fall(1'b0);
      shift_rise();
    end
    check_bus("R6 last line", exp_bus(NL - 1, 1'b0, 1'b1));
    shift_fall(1'b0);
    check_bus("R6 wrap to 0", exp_bus(0, 1'b0, 1'b1));
    shift_rise();
    shift_fall(1'b0);
    check_bus("R6 after wrap", exp_bus(1, 1'b0, 1'b1));
    shift_rise();

    // R4 with alternation high
    don_n = 1'b0;
    alt = 1'b1;
    settle();
    check_bus("R4 off", '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule